// File: doc/BRIEF.md
# Boot-Remappable Address Decoder

This block turns one bus master's 32-bit address into a one-hot slave select, an external chip-select index, an internal-window code and an abort flag. The top four address bits pick one of sixteen 256 MB regions. Region 0 is decoded further in 1 MB windows that hold the on-chip memories and the two host-interface register banks. Regions 1 to 8 go to the external bus. Region 15 goes to the peripheral bus. The remaining regions are holes that raise an abort.

The lowest 1 MB window is an alias whose target can change. While the reset input is low, the block latches a boot strap. Each master also has a remap bit that software writes. When a master's remap bit is set, that master sees internal SRAM C in the alias. When the bit is clear, the master sees the ROM if the strap was 1, or external chip select 0 if the strap was 0.

An address is presented with a one-cycle strobe and a master index. The decode result appears registered on the following cycle, qualified by `dec_valid`. There is no back-pressure. Every strobed address is decoded and its result is presented for exactly one cycle, so a consumer must take it in that cycle.

Top module: `boot_addr_decoder`

## Requirements
- R1: An address in region 1 to 8 (bits 31:28) selects the external bus (select bit 3) with `ext_cs` equal to the region number minus 1, and `int_win` equal to 0.
- R2: An address in region 15 selects the peripheral bus (select bit 4) with `ext_cs` 0 and `int_win` 0.
- R3: An address in regions 9 to 14 raises `abort`, with `slv_sel` all zero, `ext_cs` 0 and `int_win` 0.
- R4: In region 0, address bits 27:20 equal to 1, 2 or 3 select SRAM (bit 0) with `int_win` 1, 2 or 3 (bank A, B, C). A value of 4 selects ROM (bit 1) with `int_win` 4. A value of 5 selects the host interfaces (bit 2) with `int_win` 5 (USB). A value of 6 selects the host interfaces (bit 2) with `int_win` 6 (LCD).
- R5: In region 0, a value of bits 27:20 from 7 to 255 raises `abort` and selects no slave.
- R6: For the alias window (bits 31:20 all zero), a requesting master with remap clear and a strap captured as 1 gets ROM (bit 1, `int_win` 4).
- R7: For the alias window, a requesting master with remap clear and a strap captured as 0 gets the external bus (bit 3) with `ext_cs` 0 and `int_win` 0.
- R8: For the alias window, a requesting master with remap set gets SRAM (bit 0) with `int_win` 3. Each master's remap bit is independent of the other masters' bits.
- R9: The strap is sampled only while `rst_n` is low. Changes on `boot_strap` after reset do not change the alias target.
- R10: All remap bits are 0 after reset. A `remap_wr` pulse writes `remap_val` into the bit of master `remap_mst`. An address strobed in the same cycle as that write still uses the old value, and the new value applies from the next strobe on.
- R11: The result of a strobe appears in the cycle after it, with `dec_valid` high for one cycle. In a cycle that follows no strobe, `dec_valid`, `slv_sel`, `ext_cs`, `int_win` and `abort` are all 0. The same holds after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| boot_strap | input | 1 | Boot-mode strap: 1 selects ROM, 0 selects external chip select 0 |
| remap_wr | input | 1 | Remap write strobe |
| remap_mst | input | 1 | Master whose remap bit is written (0 instruction, 1 data) |
| remap_val | input | 1 | Value written to the remap bit |
| addr_vld | input | 1 | Address strobe |
| addr_mst | input | 1 | Master issuing the address |
| addr | input | 32 | Bus address |
| dec_valid | output | 1 | Decode result is valid this cycle |
| slv_sel | output | 5 | One-hot select: bit 0 SRAM, bit 1 ROM, bit 2 host interfaces, bit 3 external bus, bit 4 peripherals |
| ext_cs | output | 3 | External chip-select index |
| int_win | output | 3 | Internal window: 0 none, 1 to 3 SRAM A to C, 4 ROM, 5 USB, 6 LCD |
| abort | output | 1 | Access to an unmapped address |

## Verification
On every cycle, the assertions check the structural rules of the outputs:
- the select is one-hot or zero;
- `abort` and a select are mutually exclusive within a valid result;
- every result follows a strobe, and the outputs are quiet otherwise;
- `ext_cs` and `int_win` are used only with the matching slave;
- the strap holds steady after reset;
- the remap bits come out of reset cleared.

Only the bench scenarios can show the following:
- that each region and window reaches the right target;
- that the alias follows the strap and each master's own remap bit;
- that a remap write in the same cycle as a strobe is not seen until the next strobe;
- that toggling the strap after reset has no effect.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;
  localparam int NUM_SLV   = 5;
  localparam int SLV_SRAM  = 0;
  localparam int SLV_ROM   = 1;
  localparam int SLV_HOST  = 2;
  localparam int SLV_EXT   = 3;
  localparam int SLV_PERI  = 4;

  localparam int REG_W     = 4;
  localparam int WIN_W     = 8;
  localparam int CS_W      = 3;
  localparam int IW_W      = 3;

  localparam logic [IW_W-1:0] W_NONE  = 3'd0;
  localparam logic [IW_W-1:0] W_SRAMA = 3'd1;
  localparam logic [IW_W-1:0] W_SRAMB = 3'd2;
  localparam logic [IW_W-1:0] W_SRAMC = 3'd3;
  localparam logic [IW_W-1:0] W_ROM   = 3'd4;
  localparam logic [IW_W-1:0] W_USB   = 3'd5;
  localparam logic [IW_W-1:0] W_LCD   = 3'd6;

  typedef struct packed {
    logic [NUM_SLV-1:0] sel;
    logic [CS_W-1:0]    cs;
    logic [IW_W-1:0]    win;
    logic               abort;
  } dec_res_t;
endpackage

// File: rtl/boot_strap_cap.sv
module boot_strap_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_in,
  output logic strap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  assert_strap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/remap_regs.sv
module remap_regs #(
  parameter int NUM_MST = 2,
  localparam int MID_W = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [MID_W-1:0]   wr_mst,
  input  logic               wr_val,
  output logic [NUM_MST-1:0] remap
);
  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    always_ff @(posedge clk) begin
      if (!rst_n)
        remap[m] <= 1'b0;
      else if (wr && (wr_mst == MID_W'(m)))
        remap[m] <= wr_val;
    end

    assert_remap_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !remap[m]);
  end
endmodule

// File: rtl/region_decode.sv
module region_decode
  import boot_dec_pkg::*;
(
  input  logic [REG_W-1:0] region,
  input  logic [WIN_W-1:0] window,
  input  logic             remap_on,
  input  logic             strap,
  output dec_res_t         res
);
  always_comb begin
    res = '0;
    if (region == '0) begin
      case (window)
        8'd0: begin
          if (remap_on) begin
            res.sel[SLV_SRAM] = 1'b1;
            res.win = W_SRAMC;
          end else if (strap) begin
            res.sel[SLV_ROM] = 1'b1;
            res.win = W_ROM;
          end else begin
            res.sel[SLV_EXT] = 1'b1;
          end
        end
        8'd1: begin res.sel[SLV_SRAM] = 1'b1; res.win = W_SRAMA; end
        8'd2: begin res.sel[SLV_SRAM] = 1'b1; res.win = W_SRAMB; end
        8'd3: begin res.sel[SLV_SRAM] = 1'b1; res.win = W_SRAMC; end
        8'd4: begin res.sel[SLV_ROM]  = 1'b1; res.win = W_ROM;   end
        8'd5: begin res.sel[SLV_HOST] = 1'b1; res.win = W_USB;   end
        8'd6: begin res.sel[SLV_HOST] = 1'b1; res.win = W_LCD;   end
        default: res.abort = 1'b1;
      endcase
    end else if (region <= REG_W'(8)) begin
      res.sel[SLV_EXT] = 1'b1;
      res.cs = CS_W'(region - REG_W'(1));
    end else if (region == '1) begin
      res.sel[SLV_PERI] = 1'b1;
    end else begin
      res.abort = 1'b1;
    end
  end

  always_comb begin
    assert_excl_R3: assert (res.abort != ($countones(res.sel) == 1));
  end
endmodule

// File: rtl/boot_addr_decoder.sv
module boot_addr_decoder
  import boot_dec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_MST = 2,
  localparam int MID_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_strap,
  input  logic               remap_wr,
  input  logic [MID_W-1:0]   remap_mst,
  input  logic               remap_val,
  input  logic               addr_vld,
  input  logic [MID_W-1:0]   addr_mst,
  input  logic [ADDR_W-1:0]  addr,
  output logic               dec_valid,
  output logic [NUM_SLV-1:0] slv_sel,
  output logic [CS_W-1:0]    ext_cs,
  output logic [IW_W-1:0]    int_win,
  output logic               abort
);
  localparam int LOW_W = ADDR_W - REG_W - WIN_W;

  logic               strap_q;
  logic [NUM_MST-1:0] remap;
  dec_res_t           comb_res;
  dec_res_t           res_q;
  logic               unused_low;

  assign unused_low = ^addr[LOW_W-1:0];

  boot_strap_cap u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(boot_strap), .strap_q(strap_q)
  );

  remap_regs #(.NUM_MST(NUM_MST)) u_remap (
    .clk(clk), .rst_n(rst_n), .wr(remap_wr), .wr_mst(remap_mst),
    .wr_val(remap_val), .remap(remap)
  );

  region_decode u_dec (
    .region(addr[ADDR_W-1 -: REG_W]),
    .window(addr[ADDR_W-REG_W-1 -: WIN_W]),
    .remap_on(remap[addr_mst]),
    .strap(strap_q),
    .res(comb_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      dec_valid <= addr_vld;
      res_q     <= addr_vld ? comb_res : '0;
    end
  end

  assign slv_sel = res_q.sel;
  assign ext_cs  = res_q.cs;
  assign int_win = res_q.win;
  assign abort   = res_q.abort;

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_sel));
  assert_follows_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(addr_vld));
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (slv_sel == '0 && !abort && ext_cs == '0 && int_win == '0));
  assert_abort_nosel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (dec_valid && slv_sel == '0));
  assert_cs_ext_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs != '0) |-> slv_sel[SLV_EXT]);
  assert_win_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_win != '0) |-> (slv_sel[SLV_SRAM] || slv_sel[SLV_ROM] || slv_sel[SLV_HOST]));
endmodule

// File: tb/boot_addr_decoder_tb_top.sv
module boot_addr_decoder_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        boot_strap = 1;
  logic        remap_wr = 0, remap_mst = 0, remap_val = 0;
  logic        addr_vld = 0, addr_mst = 0;
  logic [31:0] addr = 0;
  logic        dec_valid, abort;
  logic [4:0]  slv_sel;
  logic [2:0]  ext_cs, int_win;

  int n_chk = 0, n_err = 0;
  bit m_strap;
  bit m_remap [2];

  always #5 clk = ~clk;

  boot_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
    .remap_wr(remap_wr), .remap_mst(remap_mst), .remap_val(remap_val),
    .addr_vld(addr_vld), .addr_mst(addr_mst), .addr(addr),
    .dec_valid(dec_valid), .slv_sel(slv_sel), .ext_cs(ext_cs),
    .int_win(int_win), .abort(abort)
  );

  function automatic logic [11:0] expect_of(input logic [31:0] a, input bit rm, input bit st);
    logic [4:0] s; logic [2:0] c; logic [2:0] w; logic ab;
    logic [3:0] rg; logic [7:0] wn;
    s = 0; c = 0; w = 0; ab = 0;
    rg = a[31:28]; wn = a[27:20];
    if (rg == 0) begin
      if (wn == 0) begin
        if (rm) begin s = 5'b00001; w = 3; end
        else if (st) begin s = 5'b00010; w = 4; end
        else s = 5'b01000;
      end else if (wn <= 3) begin s = 5'b00001; w = wn[2:0]; end
      else if (wn == 4) begin s = 5'b00010; w = 4; end
      else if (wn == 5 || wn == 6) begin s = 5'b00100; w = wn[2:0]; end
      else ab = 1;
    end else if (rg <= 8) begin s = 5'b01000; c = 3'(rg - 1); end
    else if (rg == 15) s = 5'b10000;
    else ab = 1;
    return {1'b1, s, c, w, ab} [11:0];
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // outputs packed as {valid, sel, cs, win, abort}
  function automatic logic [12:0] outs();
    return {dec_valid, slv_sel, ext_cs, int_win, abort};
  endfunction

  task automatic issue(input string req, input logic [31:0] a, input bit m);
    logic [12:0] e;
    @(negedge clk);
    addr_vld = 1; addr = a; addr_mst = m;
    e = {1'b1, expect_of(a, m_remap[m], m_strap)};
    @(negedge clk);
    addr_vld = 0;
    check(req, outs(), e);
  endtask

  task automatic wr_remap(input bit m, input bit v);
    @(negedge clk);
    remap_wr = 1; remap_mst = m; remap_val = v;
    @(negedge clk);
    remap_wr = 0;
    m_remap[m] = v;
  endtask

  task automatic do_reset(input bit st);
    @(negedge clk);
    rst_n = 0; boot_strap = st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_strap = st; m_remap[0] = 0; m_remap[1] = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [12:0] e;
    logic [31:0] a;
    void'($urandom(32'd1234));
    do_reset(1);
    @(negedge clk);
    check("R11 reset", outs(), 13'd0);

    // R6 strap 1, both masters
    issue("R6", 32'h0000_1234, 0);
    issue("R6", 32'h000F_FFFC, 1);
    // R4 windows
    issue("R4", 32'h0010_0000, 0);
    issue("R4", 32'h0020_0040, 1);
    issue("R4", 32'h0030_0000, 0);
    issue("R4", 32'h0040_0000, 1);
    issue("R4", 32'h0050_0010, 0);
    issue("R4", 32'h006F_FFFF, 1);
    // R5
    issue("R5", 32'h0070_0000, 0);
    issue("R5", 32'h0FFF_FFFF, 1);
    // R1 / R2 / R3
    issue("R1", 32'h1000_0000, 0);
    issue("R1", 32'h8FFF_FFFF, 1);
    issue("R2", 32'hF000_0000, 0);
    issue("R3", 32'h9000_0000, 0);
    issue("R3", 32'hE123_4567, 1);
    // R11 abort pulse: next cycle quiet
    @(negedge clk);
    check("R11 idle", outs(), 13'd0);

    // R8 per-master remap
    wr_remap(0, 1);
    issue("R8 m0", 32'h0000_0000, 0);
    issue("R8 m1 unaffected", 32'h0000_0000, 1);
    wr_remap(1, 1);
    issue("R8 m1", 32'h0008_0000, 1);
    wr_remap(0, 0);
    issue("R8 m0 cleared", 32'h0000_0000, 0);

    // R10 same-cycle write uses old value
    @(negedge clk);
    remap_wr = 1; remap_mst = 0; remap_val = 1;
    addr_vld = 1; addr = 32'h0000_0000; addr_mst = 0;
    e = {1'b1, expect_of(32'h0, 1'b0, m_strap)};
    @(negedge clk);
    remap_wr = 0; addr_vld = 0; m_remap[0] = 1;
    check("R10 same cycle", outs(), e);
    issue("R10 next strobe", 32'h0000_0000, 0);

    // R9 strap toggling after reset
    boot_strap = 0;
    wr_remap(0, 0);
    issue("R9", 32'h0000_0000, 0);
    boot_strap = 1;

    // R7 strap 0 and R10 remap cleared by reset
    do_reset(0);
    issue("R7 R10", 32'h0000_0100, 1);
    issue("R7", 32'h0000_0000, 0);
    boot_strap = 1;
    issue("R9 strap0", 32'h0001_0000, 0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      a = $urandom;
      if ($urandom_range(0, 1) == 1) begin
        a[31:28] = 0;
        a[27:20] = 8'($urandom_range(0, 8));
      end
      if ($urandom_range(0, 9) == 0) wr_remap(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      issue("R1 R4 R8 random", a, 1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule